// File: doc/BRIEF.md
# Adaptive-Width Delta Encoder

This block compresses a block of `BLOCK_LEN` unsigned samples, each `SAMPLE_W` bits wide. It keeps the first sample verbatim. Every later sample is replaced by its difference from the sample just before it. Each difference is written as a sign bit followed by a magnitude, and the magnitude field is only as wide as the data in the block needs. The encoder buffers one whole block. It then emits a header and the difference fields into a bit packer, and the packer cuts the bit stream into `OUT_W`-bit words.

There are three modes:
- **Global lossless (code 0):** one magnitude width for the whole block, set by the largest magnitude.
- **Local lossless (code 1):** each difference carries its own width in a short prefix.
- **Lossy (code 2):** one width, set by the rounded-down mean magnitude. Magnitudes that do not fit are clipped.

Samples enter on a valid/ready interface. `in_ready` is high only while a block is being collected. It drops after the last sample of a block is taken and rises again once the final word of that block has been accepted downstream. The output is a valid/ready word stream with a last flag. While `out_valid` is high and `out_ready` is low, the word and flag are held unchanged.

Top module: `adaptive_delta_encoder`

## Requirements
- R1: Each block begins with a header, sent MSB first, in this order:
  - the first sample (`SAMPLE_W` bits);
  - a 2-bit mode code: 0 = global lossless, 1 = local lossless, 2 = lossy;
  - a width field of `PW = clog2(SAMPLE_W+1)` bits.
- R2: In global lossless mode:
  - the width W is the bit length of the largest absolute difference in the block;
  - each difference is sent as its sign bit, then its magnitude in W bits, MSB first.
- R3: In local lossless mode:
  - each difference is sent as a `PW`-bit prefix holding the bit length L of its own magnitude, then its sign bit, then its magnitude in L bits;
  - a zero difference has L = 0;
  - the header width field holds the bit length of the largest magnitude.
- R4: In lossy mode:
  - W is the bit length of floor(sum of magnitudes / (BLOCK_LEN-1));
  - each difference is sent as its sign bit, then min(magnitude, 2^W-1) in W bits.
- R5: The sign bit is 1 exactly when a sample is smaller than the sample before it. Otherwise it is 0.
- R6: When W is 0 in global or lossy mode, each difference is sent as its sign bit alone.
- R7: Packing rules:
  - words are filled MSB first from the bit stream;
  - `out_last` is high on the final word of a block and on no other word;
  - the unused low bits of that final word are zero;
  - the number of words in a block is ceil(total bits / OUT_W).
- R8: Input handshake rules:
  - a sample is taken on a cycle with `in_valid` and `in_ready` both high;
  - `in_ready` is low from the cycle after the block's last sample until the block's final word is taken;
  - `in_mode` is read only together with the block's first sample.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values.
- R10: A mode input of 3 is treated as global lossless and is sent with code 0.
- R11: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Encoder accepts a sample |
| in_data | input | SAMPLE_W | Unsigned sample |
| in_mode | input | 2 | Mode for the block; read with its first sample |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | OUT_W | Packed word, oldest bit in the MSB |
| out_last | output | 1 | Final word of the block |

## Verification
No output has a fixed latency:
- the first word of a block appears a few cycles after its last sample is taken;
- later words follow at a rate set by the field widths and by `out_ready`.

The checks therefore follow the handshakes, not a cycle count:
- each word is compared at the falling edge before the rising edge that transfers it, against a bit stream the bench computes from the samples and the mode;
- under a stall, the held word is compared again one cycle later;
- `in_ready` is sampled at every falling edge on which an output word is pending;
- the word count is checked once the last-flagged word has been taken.

// File: rtl/ade_pkg.sv
package ade_pkg;

  typedef enum logic [1:0] {
    MODE_GLOBAL = 2'd0,
    MODE_LOCAL  = 2'd1,
    MODE_LOSSY  = 2'd2
  } ade_mode_e;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_HDR     = 2'd1,
    ST_DELTA   = 2'd2,
    ST_DRAIN   = 2'd3
  } ade_state_e;

  // Number of bits needed to hold v (0 for v == 0).
  function automatic int unsigned bit_len(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ade_sample_buffer.sv
module ade_sample_buffer
  import ade_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int BLOCK_LEN = 8,
  parameter int PW        = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [SAMPLE_W-1:0]          in_data,
  input  logic [1:0]                   in_mode,
  input  logic                         release_i,
  input  logic [$clog2(BLOCK_LEN)-1:0] rd_idx,
  output logic                         in_ready,
  output logic                         full,
  output logic [1:0]                   mode_q,
  output logic [PW-1:0]                width,
  output logic [SAMPLE_W-1:0]          first_s,
  output logic [SAMPLE_W-1:0]          rd_cur,
  output logic [SAMPLE_W-1:0]          rd_prev
);
  localparam int IDXW = $clog2(BLOCK_LEN);
  localparam int SUMW = SAMPLE_W + IDXW;

  logic [SAMPLE_W-1:0] mem [BLOCK_LEN];
  logic [IDXW-1:0]     wr_idx;
  logic                collecting;
  logic [SAMPLE_W-1:0] last_q, max_q, in_mag;
  logic [SUMW-1:0]     sum_q, mean;
  logic [IDXW-1:0]     prev_idx;
  logic                take;

  assign take     = in_valid && collecting;
  assign in_ready = collecting;
  assign full     = !collecting;
  assign in_mag   = (in_data >= last_q) ? (in_data - last_q) : (last_q - in_data);

  always_ff @(posedge clk) begin
    if (take) mem[wr_idx] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collecting <= 1'b1;
      wr_idx     <= '0;
      last_q     <= '0;
      max_q      <= '0;
      sum_q      <= '0;
      mode_q     <= 2'd0;
    end else begin
      if (release_i) collecting <= 1'b1;
      if (take) begin
        last_q <= in_data;
        if (wr_idx == '0) begin
          // mode is latched with the first sample only; code 3 folds to 0
          mode_q <= (in_mode == 2'd3) ? 2'd0 : in_mode;
          max_q  <= '0;
          sum_q  <= '0;
        end else begin
          if (in_mag > max_q) max_q <= in_mag;
          sum_q <= sum_q + SUMW'(in_mag);
        end
        if (wr_idx == IDXW'(BLOCK_LEN - 1)) begin
          wr_idx     <= '0;
          collecting <= 1'b0;
        end else begin
          wr_idx <= wr_idx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    mean = sum_q / SUMW'(BLOCK_LEN - 1);
    if (mode_q == MODE_LOSSY) width = PW'(bit_len(32'(mean)));
    else                      width = PW'(bit_len(32'(max_q)));
  end

  assign prev_idx = (rd_idx == '0) ? '0 : rd_idx - 1'b1;
  assign first_s  = mem[0];
  assign rd_cur   = mem[rd_idx];
  assign rd_prev  = mem[prev_idx];

  // R8: a buffered block keeps its statistics until it is released
  p_frozen_stats_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!collecting && !release_i) |=> ($stable(max_q) && $stable(sum_q) && $stable(mode_q)));

  // R10: the latched mode never carries the folded code
  p_mode_folded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_idx == '0) |=> (mode_q != 2'd3));

endmodule

// File: rtl/ade_field_gen.sv
module ade_field_gen
  import ade_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int PW       = 4,
  parameter int FMAX     = 14,
  parameter int LENW     = 4
) (
  input  logic                is_hdr,
  input  logic [1:0]          mode,
  input  logic [PW-1:0]       width,
  input  logic [SAMPLE_W-1:0] first_s,
  input  logic [SAMPLE_W-1:0] cur,
  input  logic [SAMPLE_W-1:0] prev,
  output logic [LENW-1:0]     f_len,
  output logic [FMAX-1:0]     f_bits
);
  logic                neg;
  logic [SAMPLE_W-1:0] mag, maxv, satmag;
  logic [PW-1:0]       lw;
  logic [PW:0]         lw_sh;

  always_comb begin
    neg    = cur < prev;
    mag    = neg ? (prev - cur) : (cur - prev);
    maxv   = SAMPLE_W'((FMAX'(1) << width) - FMAX'(1));
    satmag = (mode == MODE_LOSSY && mag > maxv) ? maxv : mag;
    lw     = PW'(bit_len(32'(mag)));
    lw_sh  = (PW+1)'(lw) + (PW+1)'(1);
    if (is_hdr) begin
      f_bits = FMAX'({first_s, mode, width});
      f_len  = LENW'(SAMPLE_W + 2 + PW);
    end else if (mode == MODE_LOCAL) begin
      f_bits = (FMAX'(lw) << lw_sh) | (FMAX'(neg) << lw) | FMAX'(mag);
      f_len  = LENW'(PW + 1) + LENW'(lw);
    end else begin
      f_bits = (FMAX'(neg) << width) | FMAX'(satmag);
      f_len  = LENW'(1) + LENW'(width);
    end
  end

endmodule

// File: rtl/ade_bit_packer.sv
module ade_bit_packer #(
  parameter int OUT_W = 16,
  parameter int FMAX  = 14,
  parameter int LENW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_valid,
  input  logic [LENW-1:0]  f_len,
  input  logic [FMAX-1:0]  f_bits,
  input  logic             f_end,
  output logic             f_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last,
  output logic             done
);
  localparam int ACC_W = OUT_W + FMAX;
  localparam int CNTW  = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc, placed;
  logic [CNTW-1:0]  cnt, shift;
  logic             end_q, push, pop;

  assign f_ready   = (cnt < CNTW'(OUT_W)) && !end_q;
  assign out_valid = (cnt >= CNTW'(OUT_W)) || (end_q && cnt != '0);
  assign out_last  = end_q && (cnt <= CNTW'(OUT_W));
  assign out_data  = acc[ACC_W-1 -: OUT_W];
  assign push      = f_valid && f_ready;
  assign pop       = out_valid && out_ready;
  assign done      = pop && out_last;
  assign shift     = CNTW'(ACC_W) - CNTW'(f_len) - cnt;
  assign placed    = ACC_W'(f_bits) << shift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      cnt   <= '0;
      end_q <= 1'b0;
    end else if (push) begin
      acc <= acc | placed;
      cnt <= cnt + CNTW'(f_len);
      if (f_end) end_q <= 1'b1;
    end else if (pop) begin
      acc <= acc << OUT_W;
      cnt <= (cnt > CNTW'(OUT_W)) ? cnt - CNTW'(OUT_W) : '0;
      if (out_last) end_q <= 1'b0;
    end
  end

  // R9: stalled output holds
  p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R7: accumulator never overfills
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(ACC_W));

  // R7: nothing remains after the last word leaves
  p_last_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid);

  // R3: every accepted field fits the widest field slot
  p_field_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (f_len <= LENW'(FMAX) && f_len != '0));

endmodule

// File: rtl/adaptive_delta_encoder.sv
module adaptive_delta_encoder
  import ade_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int BLOCK_LEN = 8,
  parameter int OUT_W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic [1:0]          in_mode,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OUT_W-1:0]    out_data,
  output logic                out_last
);
  localparam int PW   = $clog2(SAMPLE_W + 1);
  localparam int FMAX = SAMPLE_W + PW + 2;
  localparam int LENW = $clog2(FMAX + 1);
  localparam int IDXW = $clog2(BLOCK_LEN);

  ade_state_e          state;
  logic [IDXW-1:0]     j;
  logic                buf_full, pk_done, f_valid, f_ready, f_end, is_hdr;
  logic [1:0]          mode_q;
  logic [PW-1:0]       width;
  logic [SAMPLE_W-1:0] first_s, rd_cur, rd_prev;
  logic [LENW-1:0]     f_len;
  logic [FMAX-1:0]     f_bits;

  ade_sample_buffer #(.SAMPLE_W(SAMPLE_W), .BLOCK_LEN(BLOCK_LEN), .PW(PW)) buf_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_mode(in_mode),
    .release_i(pk_done), .rd_idx(j), .in_ready(in_ready), .full(buf_full),
    .mode_q(mode_q), .width(width), .first_s(first_s), .rd_cur(rd_cur), .rd_prev(rd_prev)
  );

  ade_field_gen #(.SAMPLE_W(SAMPLE_W), .PW(PW), .FMAX(FMAX), .LENW(LENW)) gen_i (
    .is_hdr(is_hdr), .mode(mode_q), .width(width), .first_s(first_s),
    .cur(rd_cur), .prev(rd_prev), .f_len(f_len), .f_bits(f_bits)
  );

  ade_bit_packer #(.OUT_W(OUT_W), .FMAX(FMAX), .LENW(LENW)) pack_i (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_len(f_len), .f_bits(f_bits),
    .f_end(f_end), .f_ready(f_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .done(pk_done)
  );

  assign is_hdr  = (state == ST_HDR);
  assign f_valid = (state == ST_HDR) || (state == ST_DELTA);
  assign f_end   = (state == ST_DELTA) && (j == IDXW'(BLOCK_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_COLLECT;
      j     <= '0;
    end else begin
      unique case (state)
        ST_COLLECT: if (buf_full) begin
          state <= ST_HDR;
          j     <= '0;
        end
        ST_HDR: if (f_ready) begin
          state <= ST_DELTA;
          j     <= IDXW'(1);
        end
        ST_DELTA: if (f_ready) begin
          if (f_end) state <= ST_DRAIN;
          else       j <= j + 1'b1;
        end
        ST_DRAIN: if (pk_done) state <= ST_COLLECT;
        default: state <= ST_COLLECT;
      endcase
    end
  end

  // R8: input and output phases never overlap
  p_phase_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R8: no sample is taken while a block is being emitted
  p_no_take_emitting_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_COLLECT) |-> !in_ready || pk_done || $past(pk_done));

endmodule

// File: tb/adaptive_delta_encoder_tb.sv
`timescale 1ns/1ps
module adaptive_delta_encoder_tb_top;
  localparam int SW = 4;
  localparam int BL = 8;
  localparam int OW = 8;
  localparam int PWB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_data = '0;
  logic [1:0]    in_mode = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [OW-1:0] out_data;
  logic          out_last;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit exp_bits [0:511];
  int nbits;
  int blk [0:BL-1];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  adaptive_delta_encoder #(.SAMPLE_W(SW), .BLOCK_LEN(BL), .OUT_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  function automatic int bl(input int v);
    int r = 0;
    for (int i = 0; i < 31; i++) if (v[i]) r = i + 1;
    return r;
  endfunction

  function automatic void push(input int v, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      exp_bits[nbits] = v[i];
      nbits++;
    end
  endfunction

  // Reference bit stream, computed from R1..R6 and R10
  function automatic void build_expected(input int m);
    int me, mx, sum, w, mag, neg, lw, sat;
    me = (m == 3) ? 0 : m;
    mx = 0; sum = 0;
    for (int k = 1; k < BL; k++) begin
      mag = (blk[k] >= blk[k-1]) ? blk[k] - blk[k-1] : blk[k-1] - blk[k];
      if (mag > mx) mx = mag;
      sum += mag;
    end
    w = (me == 2) ? bl(sum / (BL - 1)) : bl(mx);
    nbits = 0;
    push(blk[0], SW); push(me, 2); push(w, PWB);
    for (int k = 1; k < BL; k++) begin
      neg = (blk[k] < blk[k-1]) ? 1 : 0;
      mag = neg ? blk[k-1] - blk[k] : blk[k] - blk[k-1];
      if (me == 1) begin
        lw = bl(mag);
        push(lw, PWB); push(neg, 1); push(mag, lw);
      end else begin
        sat = (mag > (1 << w) - 1) ? (1 << w) - 1 : mag;
        push(neg, 1); push(sat, w);
      end
    end
  endfunction

  task automatic send_block(input int m);
    for (int k = 0; k < BL; k++) begin
      if (step_lfsr()) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = SW'(blk[k]);
      in_mode  = (k == 0) ? 2'(m) : ~2'(m);  // later mode values must be ignored (R8)
      #1;
      while (in_ready !== 1'b1) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv_block(input string tag, input int rmode);
    int wi = 0;
    int nwords = (nbits + OW - 1) / OW;
    bit got_last = 0;
    bit held = 0;
    logic [OW-1:0] hdata = '0;
    logic hlast = 0;
    logic [OW-1:0] ew;
    int spins = 0;
    while (!got_last && spins < 2000) begin
      spins++;
      @(negedge clk);
      #1;
      if (held) begin
        check(out_valid === 1'b1 && out_data === hdata && out_last === hlast,
              "R9", "stalled word changed", int'(out_data), int'(hdata));
      end
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = ~out_ready;
        default: out_ready = step_lfsr();
      endcase
      #1;
      if (out_valid) check(in_ready === 1'b0, "R8", "in_ready during emission", int'(in_ready), 0);
      held = out_valid && !out_ready;
      hdata = out_data;
      hlast = out_last;
      if (out_valid && out_ready) begin
        for (int b = 0; b < OW; b++) begin
          int idx = wi * OW + b;
          ew[OW-1-b] = (idx < nbits) ? exp_bits[idx] : 1'b0;
        end
        check(out_data === ew, (wi == 0) ? "R1" : tag, "word", int'(out_data), int'(ew));
        check(out_last === (wi == nwords - 1), "R7", "last flag", int'(out_last),
              int'(wi == nwords - 1));
        wi++;
        if (out_last === 1'b1) got_last = 1;
      end
      @(posedge clk);
    end
    check(wi == nwords, "R7", "word count", wi, nwords);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run(input int m, input string tag, input int rmode);
    build_expected(m);
    send_block(m);
    recv_block(tag, rmode);
  endtask

  task automatic set_blk(input int a, b, c, d, e, f, g, h);
    blk[0] = a; blk[1] = b; blk[2] = c; blk[3] = d;
    blk[4] = e; blk[5] = f; blk[6] = g; blk[7] = h;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(in_ready === 1'b1, "R11", "in_ready after reset", int'(in_ready), 1);
    check(out_valid === 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);

    set_blk(0, 0, 0, 1, 3, 5, 5, 6);
    run(0, "R2", 0);
    run(1, "R3", 0);
    run(2, "R4", 1);
    run(3, "R10", 0);
    set_blk(9, 9, 9, 9, 9, 9, 9, 9);
    run(0, "R6", 0);
    run(2, "R6", 1);
    set_blk(15, 13, 12, 8, 8, 3, 1, 0);
    run(0, "R5", 1);
    run(1, "R5", 2);
    set_blk(0, 15, 0, 15, 0, 15, 0, 15);
    run(2, "R4", 0);
    run(1, "R3", 1);
    set_blk(0, 15, 0, 0, 0, 0, 0, 1);
    run(2, "R4", 2);   // mean 4 -> width 3, magnitude 15 clips to 7

    for (int b = 0; b < 160; b++) begin
      for (int k = 0; k < BL; k++) blk[k] = int'(lfsr[3:0] ^ lfsr[11:8]) + (step_lfsr() ? 0 : 0);
      for (int k = 0; k < BL; k++) begin
        void'(step_lfsr()); void'(step_lfsr()); void'(step_lfsr());
        blk[k] = (b % 2 == 0) ? int'(lfsr[3:0]) : ((blk[(k == 0) ? 0 : k-1] + int'(lfsr[1:0])) & 15);
      end
      case (b % 4)
        0: run(0, "R2", b % 3);
        1: run(1, "R3", b % 3);
        2: run(2, "R4", b % 3);
        default: run(3, "R10", b % 3);
      endcase
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule